// File: doc/BRIEF.md
# BCD Calendar Timekeeping Counter

This block holds wall-clock time and calendar date as packed-BCD fields: seconds, minutes, hours, day of month, weekday, month and a two-digit year covering 2000 to 2099. A one-cycle enable pulse from an external 1 Hz source advances the time by one second. Each carry ripples upward through the fields and follows month lengths and leap years.

A host reaches the block through a byte-wide register port. A control byte sits at address 0. The seven time fields follow it at consecutive addresses. The host can select 12-hour or 24-hour hour encoding, freeze counting, or return the time to its reset state.

The top bit of the seconds byte is a sticky integrity flag. It is set at reset, on a soft reset, and whenever the external oscillator-fail input is high. It tells software that the time cannot be trusted until the seconds byte has been written again.

Top module: `rtc_bcd_clock`

## Requirements
- R1: After reset the port reads: control 0x00, seconds 0x80 (integrity flag set, value 00), minutes 0x00, hours 0x00, date 0x01, weekday 0x00, month 0x01, year 0x00.
- R2: Address 0 is the control byte. Addresses 1 to 7 are seconds, minutes, hours, date, weekday, month and year, in that order. Each time field keeps only its defined bits and reads 0 in all other bits: seconds 6:0 (bit 7 is the flag), minutes 6:0, hours 5:0, date 5:0, weekday 2:0, month 4:0, year 7:0.
- R3: Each cycle with the tick enable high (and no host write, counting not stopped) advances seconds by one in BCD. Seconds 0x59 wraps to 0x00 and advances minutes. Minutes 0x59 wraps to 0x00 and advances hours.
- R4: With control bit 3 at 0 (24-hour mode), hours count 0x00 to 0x23 in BCD. The step after 0x23 gives 0x00 and advances the date and the weekday.
- R5: With control bit 3 at 1 (12-hour mode), hours bits 4:0 hold BCD 1 to 12 and bit 5 marks PM. The step after 11 toggles PM and gives 12. The step after 12 gives 01 with PM unchanged. The date advances only on the step from 11 PM to 12 AM.
- R6: The date wraps to 0x01 and advances the month after the last day of the month: 30 for months 4, 6, 9 and 11; 31 for the other months except February; for February, 29 when the year is divisible by 4 and 28 otherwise.
- R7: Month 0x12 wraps to 0x01 and advances the year. Year 0x99 wraps to 0x00. Weekday counts 0 to 6 and wraps to 0 on each date advance.
- R8: The integrity flag (seconds bit 7) is set by reset and by the oscillator-fail input. Ticks leave it unchanged. A seconds write loads the flag from bit 7 of the write data, so a write with bit 7 at 0 clears it, unless oscillator-fail is high in that cycle.
- R9: While control bit 5 (stop) is 1, ticks do not change any time field.
- R10: A host write to a time field takes effect on the next clock edge. A tick in that same cycle is dropped.
- R11: Writing the control byte with bit 4 set returns all time fields to their reset values and sets the flag. Bits 3 and 5 still load from the write data. Bit 4 always reads 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| tickEn | input | 1 | One-second advance enable, one cycle wide |
| oscFail | input | 1 | Oscillator failure indication, sets the integrity flag |
| wrEn | input | 1 | Host write strobe |
| addr | input | ADDR_W | Register address for read and write |
| wrData | input | 8 | Host write data |
| rdData | output | 8 | Read data of the addressed register, combinational |

## Verification
The assertions check on every cycle that a tick at 59 seconds wraps to zero, that a seconds field nobody writes or ticks holds still, that oscillator failure raises the flag on the next edge, that a minutes write lands as written, and that the date and year wrap at their limits. Only one register is addressed at a time. Month-length and leap-year decoding for every month of all hundred years, the full 12-hour hour cycle, the stop bit, soft reset and a write colliding with a tick can only be shown by the bench's sweeps. Those sweeps compare the read port against arithmetic computed in the bench.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

  localparam int FIELD_CNT = 7;

  localparam int F_SEC  = 0;
  localparam int F_MIN  = 1;
  localparam int F_HOUR = 2;
  localparam int F_DATE = 3;
  localparam int F_WDAY = 4;
  localparam int F_MON  = 5;
  localparam int F_YEAR = 6;

  typedef struct packed {
    logic [FIELD_CNT-1:0] loadField;
    logic                 loadCtrl;
    logic                 softRst;
    logic                 advance;
  } rtc_strobe_t;

  // BCD step: returns {wrap, next}; at or past 'last' it wraps to 'first'
  function automatic logic [8:0] bcdStep(input logic [7:0] cur,
                                         input logic [7:0] last,
                                         input logic [7:0] first);
    logic [8:0] res;
    if (cur >= last)            res = {1'b1, first};
    else if (cur[3:0] >= 4'd9)  res = {1'b0, cur[7:4] + 4'd1, 4'd0};
    else                        res = {1'b0, cur[7:4], cur[3:0] + 4'd1};
    return res;
  endfunction

  // divisible by four, BCD year: tens even -> units 0/4/8, tens odd -> 2/6
  function automatic logic isLeap(input logic [7:0] yr);
    logic r;
    if (!yr[4]) r = (yr[3:0] == 4'd0) || (yr[3:0] == 4'd4) || (yr[3:0] == 4'd8);
    else        r = (yr[3:0] == 4'd2) || (yr[3:0] == 4'd6);
    return r;
  endfunction

  function automatic logic [7:0] monthLast(input logic [7:0] mon,
                                           input logic [7:0] yr);
    logic [7:0] d;
    case (mon)
      8'h02:                      d = isLeap(yr) ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: d = 8'h30;
      default:                    d = 8'h31;
    endcase
    return d;
  endfunction

endpackage

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int CTRL_ADDR = 0,
  parameter int TIME_BASE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              softBit,
  input  logic              halted,
  output rtc_strobe_t       stb
);

  logic [FIELD_CNT-1:0] fieldHit;

  generate
    for (genvar i = 0; i < FIELD_CNT; i++) begin : g_hit
      assign fieldHit[i] = wrEn && (addr == ADDR_W'(TIME_BASE + i));
    end
  endgenerate

  always_comb begin
    stb           = '0;
    stb.loadField = fieldHit;
    stb.loadCtrl  = wrEn && (addr == ADDR_W'(CTRL_ADDR));
    stb.softRst   = stb.loadCtrl && softBit;
    // any host write cycle swallows the tick
    stb.advance   = tickEn && !halted && !wrEn;
  end

  // R2: a write reaches at most one register
  a_r2_one_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.loadField, stb.loadCtrl}));

  // R9: a stopped clock never emits an advance
  a_r9_halt_blocks: assert property (@(posedge clk) disable iff (!rstN)
    halted |-> !stb.advance);

endmodule

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int CTRL_ADDR = 0,
  parameter int TIME_BASE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  rtc_strobe_t       stb,
  input  logic [7:0]        wrData,
  input  logic              oscFail,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic [7:0]        rdData,
  output logic              halted
);

  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(TIME_BASE);
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
  localparam logic [ADDR_W-1:0] CNT_A  = ADDR_W'(FIELD_CNT);

  logic [7:0] secR, minR, hourR, dateR, wdayR, monR, yrR;
  logic       oscFlag, twelveHour, haltBit;

  logic [8:0] secStep, minStep, hour24Step, dateStep, monStep, yrStep;
  logic [7:0] lastDay, h12, h12Next, hourNext, wdayNext;
  logic       pmNext, hourCarry, dayTick;

  assign secStep    = bcdStep(secR, 8'h59, 8'h00);
  assign minStep    = bcdStep(minR, 8'h59, 8'h00);
  assign hour24Step = bcdStep(hourR, 8'h23, 8'h00);
  assign lastDay    = monthLast(monR, yrR);
  assign dateStep   = bcdStep(dateR, lastDay, 8'h01);
  assign monStep    = bcdStep(monR, 8'h12, 8'h01);
  assign yrStep     = bcdStep(yrR, 8'h99, 8'h00);
  assign wdayNext   = (wdayR >= 8'd6) ? 8'd0 : wdayR + 8'd1;
  assign dayTick    = stb.advance && secStep[8] && minStep[8] && hourCarry;

  always_comb begin
    h12     = hourR & 8'h1F;
    h12Next = 8'h01;
    pmNext  = hourR[5];
    if (twelveHour) begin
      if (h12 == 8'h12)          h12Next = 8'h01;
      else if (h12[3:0] == 4'h9) h12Next = {h12[7:4] + 4'd1, 4'h0};
      else                       h12Next = h12 + 8'd1;
      pmNext    = (h12 == 8'h11) ? ~hourR[5] : hourR[5];
      hourNext  = h12Next | {2'b00, pmNext, 5'b00000};
      hourCarry = (h12 == 8'h11) && hourR[5];
    end else begin
      hourNext  = hour24Step[7:0];
      hourCarry = hour24Step[8];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      secR <= 8'h00; minR <= 8'h00; hourR <= 8'h00; dateR <= 8'h01;
      wdayR <= 8'h00; monR <= 8'h01; yrR <= 8'h00;
      oscFlag <= 1'b1; twelveHour <= 1'b0; haltBit <= 1'b0;
    end else begin
      if (stb.softRst) begin
        secR <= 8'h00; minR <= 8'h00; hourR <= 8'h00; dateR <= 8'h01;
        wdayR <= 8'h00; monR <= 8'h01; yrR <= 8'h00;
      end else if (stb.advance) begin
        secR <= secStep[7:0];
        if (secStep[8]) begin
          minR <= minStep[7:0];
          if (minStep[8]) begin
            hourR <= hourNext;
            if (hourCarry) begin
              dateR <= dateStep[7:0];
              wdayR <= wdayNext;
              if (dateStep[8]) begin
                monR <= monStep[7:0];
                if (monStep[8]) yrR <= yrStep[7:0];
              end
            end
          end
        end
      end else begin
        if (stb.loadField[F_SEC])  secR  <= wrData & 8'h7F;
        if (stb.loadField[F_MIN])  minR  <= wrData & 8'h7F;
        if (stb.loadField[F_HOUR]) hourR <= wrData & 8'h3F;
        if (stb.loadField[F_DATE]) dateR <= wrData & 8'h3F;
        if (stb.loadField[F_WDAY]) wdayR <= wrData & 8'h07;
        if (stb.loadField[F_MON])  monR  <= wrData & 8'h1F;
        if (stb.loadField[F_YEAR]) yrR   <= wrData;
      end
      if (stb.loadCtrl) begin
        twelveHour <= wrData[3];
        haltBit    <= wrData[5];
      end
      if (oscFail || stb.softRst)     oscFlag <= 1'b1;
      else if (stb.loadField[F_SEC])  oscFlag <= wrData[7];
    end
  end

  assign halted = haltBit;

  logic [ADDR_W-1:0] idx;
  logic [7:0]        fieldVal [FIELD_CNT];
  assign idx = rdAddr - BASE_A;

  always_comb begin
    fieldVal[F_SEC]  = {oscFlag, secR[6:0]};
    fieldVal[F_MIN]  = minR;
    fieldVal[F_HOUR] = hourR;
    fieldVal[F_DATE] = dateR;
    fieldVal[F_WDAY] = wdayR;
    fieldVal[F_MON]  = monR;
    fieldVal[F_YEAR] = yrR;
    rdData = 8'h00;
    if (rdAddr == CTRL_A)
      rdData = {2'b00, haltBit, 1'b0, twelveHour, 3'b000};
    else if (rdAddr >= BASE_A && idx < CNT_A)
      rdData = fieldVal[idx];
  end

  // R3: a tick at 59 seconds wraps seconds to zero
  a_r3_sec_wrap: assert property (@(posedge clk) disable iff (!rstN)
    stb.advance && secR == 8'h59 |=> secR == 8'h00);

  // R8: oscillator failure raises the flag on the next edge
  a_r8_fail_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    oscFail |=> oscFlag);

  // R9: seconds hold when neither ticked, written nor soft-reset
  a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !stb.advance && !stb.softRst && !stb.loadField[F_SEC] |=> $stable(secR));

  // R10: a minutes write lands as written, masked to its field
  a_r10_write_lands: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadField[F_MIN] |=> minR == ($past(wrData) & 8'h7F));

  // R6: date wraps to the first on a day advance at month end
  a_r6_month_end: assert property (@(posedge clk) disable iff (!rstN)
    dayTick && dateR == lastDay |=> dateR == 8'h01);

  // R7: year wraps at 99 when December ends
  a_r7_year_wrap: assert property (@(posedge clk) disable iff (!rstN)
    dayTick && dateStep[8] && monStep[8] && yrStep[8] |=> yrR == 8'h00);

endmodule

// File: rtl/rtc_bcd_clock.sv
module rtc_bcd_clock
  import rtc_pkg::*;
#(
  parameter int ADDR_W    = 3,
  parameter int CTRL_ADDR = 0,
  parameter int TIME_BASE = 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic              oscFail,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData
);

  rtc_strobe_t stb;
  logic        halted;

  rtc_ctrl #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .TIME_BASE(TIME_BASE)) u_ctrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .wrEn(wrEn), .addr(addr),
    .softBit(wrData[4]), .halted(halted), .stb(stb)
  );

  rtc_datapath #(.ADDR_W(ADDR_W), .CTRL_ADDR(CTRL_ADDR), .TIME_BASE(TIME_BASE)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData), .oscFail(oscFail),
    .rdAddr(addr), .rdData(rdData), .halted(halted)
  );

endmodule

// File: tb/rtc_bcd_clock_tb.sv
module rtc_bcd_clock_tb;

  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W     = 3;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              tickEn = 1'b0;
  logic              oscFail = 1'b0;
  logic              wrEn = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0]        wrData = 8'h00;
  logic [7:0]        rdData;

  int  compared = 0;
  int  mismatched = 0;
  bit  done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rtc_bcd_clock #(.ADDR_W(ADDR_W)) u_dut (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .oscFail(oscFail),
    .wrEn(wrEn), .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  function automatic logic [7:0] b(input int v);
    return 8'((v / 10) * 16 + (v % 10));
  endfunction

  function automatic int dim(input int m, input int y);
    if (m == 2) return (y % 4 == 0) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic chk(input string req, input int a, input logic [7:0] exp);
    addr = ADDR_W'(a);
    #1;
    compared++;
    if (rdData !== exp) begin
      mismatched++;
      $display("FAIL %s addr %0d: got %02h expected %02h", req, a, rdData, exp);
    end
  endtask

  task automatic wr(input int a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = ADDR_W'(a); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tickEn = 1'b1;
      @(negedge clk); tickEn = 1'b0;
    end
  endtask

  task automatic setAll(input logic [7:0] s, m, h, d, w, mo, y);
    wr(1, s); wr(2, m); wr(3, h); wr(4, d); wr(5, w); wr(6, mo); wr(7, y);
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: got hang expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", 0, 8'h00); chk("R1", 1, 8'h80); chk("R1", 2, 8'h00);
    chk("R1", 3, 8'h00); chk("R1", 4, 8'h01); chk("R1", 5, 8'h00);
    chk("R1", 6, 8'h01); chk("R1", 7, 8'h00);

    // R8 flag kept across ticks, cleared by write, set by failure
    tick(1);
    chk("R8", 1, 8'h81);
    wr(1, 8'h00);
    chk("R8", 1, 8'h00);
    @(negedge clk); oscFail = 1'b1;
    @(negedge clk); oscFail = 1'b0;
    chk("R8", 1, 8'h80);
    wr(1, 8'h30);
    chk("R8", 1, 8'h30);

    // R2 field masking
    wr(2, 8'hFF); chk("R2", 2, 8'h7F);
    wr(5, 8'hFF); chk("R2", 5, 8'h07);
    wr(6, 8'hFF); chk("R2", 6, 8'h1F);

    // R3 seconds sweep across a minute
    setAll(8'h00, 8'h00, 8'h05, 8'h10, 8'h02, 8'h03, 8'h21);
    for (int s = 1; s <= 60; s++) begin
      tick(1);
      chk("R3", 1, b(s % 60));
    end
    chk("R3", 2, 8'h01);
    setAll(8'h59, 8'h59, 8'h05, 8'h10, 8'h02, 8'h03, 8'h21);
    tick(1);
    chk("R3", 1, 8'h00); chk("R3", 2, 8'h00); chk("R3", 3, 8'h06);

    // R4 24-hour sweep
    for (int h = 0; h < 24; h++) begin
      setAll(8'h59, 8'h59, b(h), 8'h10, 8'h02, 8'h03, 8'h21);
      tick(1);
      chk("R4", 3, b((h + 1) % 24));
      chk("R4", 4, (h == 23) ? 8'h11 : 8'h10);
    end

    // R5 12-hour sweep
    wr(0, 8'h08);
    chk("R5", 0, 8'h08);
    for (int pm = 0; pm < 2; pm++) begin
      for (int h = 1; h <= 12; h++) begin
        int h24, n, hn;
        h24 = (h % 12) + (pm ? 12 : 0);
        n   = (h24 + 1) % 24;
        hn  = (n % 12 == 0) ? 12 : n % 12;
        setAll(8'h59, 8'h59, b(h) | (pm ? 8'h20 : 8'h00), 8'h10, 8'h02, 8'h03, 8'h21);
        tick(1);
        chk("R5", 3, b(hn) | ((n >= 12) ? 8'h20 : 8'h00));
        chk("R5", 4, (h24 == 23) ? 8'h11 : 8'h10);
      end
    end
    wr(0, 8'h00);

    // R6 R7 month ends across every year
    for (int y = 0; y < 100; y++) begin
      for (int m = 1; m <= 12; m++) begin
        int d, w;
        d = dim(m, y);
        w = (y + m) % 7;
        setAll(8'h59, 8'h59, 8'h23, b(d - 1), b(w), b(m), b(y));
        tick(1);
        chk("R6", 4, b(d));
        chk("R6", 6, b(m));
        wr(1, 8'h59); wr(2, 8'h59); wr(3, 8'h23);
        tick(1);
        chk("R6", 4, 8'h01);
        chk("R7", 5, b((w + 2) % 7));
        chk("R7", 6, b(m == 12 ? 1 : m + 1));
        chk("R7", 7, b(m == 12 ? (y + 1) % 100 : y));
      end
    end

    // R9 stop bit
    setAll(8'h20, 8'h00, 8'h01, 8'h01, 8'h00, 8'h01, 8'h00);
    wr(0, 8'h20);
    chk("R9", 0, 8'h20);
    tick(3);
    chk("R9", 1, 8'h20);
    wr(0, 8'h00);
    tick(1);
    chk("R9", 1, 8'h21);

    // R10 write collides with a tick
    wr(1, 8'h10);
    @(negedge clk);
    wrEn = 1'b1; addr = 3'd2; wrData = 8'h33; tickEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; tickEn = 1'b0;
    chk("R10", 2, 8'h33);
    chk("R10", 1, 8'h10);

    // R11 soft reset
    setAll(8'h42, 8'h17, 8'h09, 8'h22, 8'h04, 8'h07, 8'h55);
    wr(0, 8'h18);
    chk("R11", 0, 8'h08); chk("R11", 1, 8'h80); chk("R11", 2, 8'h00);
    chk("R11", 3, 8'h00); chk("R11", 4, 8'h01); chk("R11", 5, 8'h00);
    chk("R11", 6, 8'h01); chk("R11", 7, 8'h00);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule